// File: doc/BRIEF.md
# Inverse-Order Flit Queue Allocator

This block decides where an arriving head flit is stored in a six-queue router for a three-dimensional mesh. From the destination coordinates and the router's own coordinates it works out the next hop with dimension-ordered routing: X is resolved first, then Y, then Z. It then walks the six input queues in a fixed order, from the queue that accepts the fewest directions to the one that accepts the most: Up, Down, North, South, East, West. It picks the first queue that may legally hold a flit bound for that hop and still has a free slot.

A queue's fill level counts only as a single not-full flag. The block does no comparison of occupancies and needs no sorting network. The walk order alone spreads load away from the flexible X-dimension queues. When no queue qualifies, the block raises a blocked flag, and the sender keeps its request and retries. The next-hop code comes out with each answer so that it can be written into the head flit.

The answer is registered and appears one clock after the request. Queue storage and output arbitration belong to other blocks.

Top module: `qbuf_scan_alloc`

## Requirements
- R1: When the destination X differs from the local X, the hop tag is East (code 1) if the destination X is greater, otherwise West (code 2). Coordinates are compared as unsigned numbers.
- R2: When the X values match but the Y values differ, the hop tag is North (code 3) if the destination Y is greater, otherwise South (code 4).
- R3: When X and Y both match, the hop tag is Up (code 5) for a greater destination Z, Down (code 6) for a smaller one, and Local (code 0) when Z also matches.
- R4: The select bits are bit 0 Up, bit 1 Down, bit 2 North, bit 3 South, bit 4 East, bit 5 West. A queue may be selected only for these hops: Up queue {Down, Local}; Down queue {Up, Local}; North queue {South, Up, Down, Local}; South queue {North, Up, Down, Local}; East queue every hop except East; West queue every hop except West.
- R5: A queue may be selected only if its not-full flag (q_not_full, same bit order as the select) was high when the request was sampled.
- R6: Among the queues that qualify, the one with the lowest select bit index wins, which gives the order Up, Down, North, South, East, West.
- R7: A flit bound West can only go to the East queue. A flit bound East can only go to the West queue.
- R8: If a valid request finds no qualifying queue, blocked is 1 and the select is all zero.
- R9: A cycle with no request yields rsp_vld 0, an all-zero select and blocked 0.
- R10: The response (rsp_vld, q_sel, blocked, hop_tag) appears on the clock edge after the request is sampled. While in reset, rsp_vld, q_sel and blocked are zero.
- R11: The select is one-hot or zero, and it is never nonzero in the same cycle as blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A head flit requests a queue this cycle |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| dst_z | input | CW | Destination Z coordinate |
| loc_x | input | CW | Router's own X coordinate |
| loc_y | input | CW | Router's own Y coordinate |
| loc_z | input | CW | Router's own Z coordinate |
| q_not_full | input | 6 | Per-queue free-slot flags, bit order as q_sel |
| rsp_vld | output | 1 | Response valid |
| q_sel | output | 6 | One-hot chosen queue |
| blocked | output | 1 | No queue could take the flit |
| hop_tag | output | 3 | Next-hop code for the head flit |

## Verification
The assertions watch the structural rules on every cycle. They check that the select is one-hot and never paired with blocked, that an idle cycle gives an idle response, that a chosen queue was not full and may legally hold the tagged hop, and that a West-bound flit lands only in the East queue. Only the bench's scenarios can show the rest: that the hop code is correct for each coordinate relation, that the first qualifying queue in walk order is chosen over later ones, and that blocking happens exactly when every legal queue is full. The bench compares each response with a reference computed on its own.

// File: rtl/qbuf_scan_alloc_pkg.sv
package qbuf_scan_alloc_pkg;

  localparam int NUM_Q = 6;
  localparam int HOP_W = 3;

  typedef enum logic [HOP_W-1:0] {
    HOP_LOCAL = 3'd0,
    HOP_EAST  = 3'd1,
    HOP_WEST  = 3'd2,
    HOP_NORTH = 3'd3,
    HOP_SOUTH = 3'd4,
    HOP_UP    = 3'd5,
    HOP_DOWN  = 3'd6
  } hop_e;

  // Queue index equals scan rank: lower index is searched first.
  localparam int Q_UP    = 0;
  localparam int Q_DOWN  = 1;
  localparam int Q_NORTH = 2;
  localparam int Q_SOUTH = 3;
  localparam int Q_EAST  = 4;
  localparam int Q_WEST  = 5;

  // Deadlock-safe holding rule: may queue q keep a flit bound for hop h?
  function automatic logic q_accepts(input int q, input hop_e h);
    logic ok;
    ok = 1'b0;
    case (q)
      Q_UP:    ok = (h == HOP_DOWN) || (h == HOP_LOCAL);
      Q_DOWN:  ok = (h == HOP_UP)   || (h == HOP_LOCAL);
      Q_NORTH: ok = (h == HOP_SOUTH) || (h == HOP_UP) ||
                    (h == HOP_DOWN)  || (h == HOP_LOCAL);
      Q_SOUTH: ok = (h == HOP_NORTH) || (h == HOP_UP) ||
                    (h == HOP_DOWN)  || (h == HOP_LOCAL);
      Q_EAST:  ok = (h != HOP_EAST);
      Q_WEST:  ok = (h != HOP_WEST);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/qbuf_hop_route.sv
module qbuf_hop_route
  import qbuf_scan_alloc_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] dst_z,
  input  logic [CW-1:0] loc_x,
  input  logic [CW-1:0] loc_y,
  input  logic [CW-1:0] loc_z,
  output hop_e          hop
);

  // Dimension order: X, then Y, then Z.
  always_comb begin
    if (dst_x != loc_x) begin
      hop = (dst_x > loc_x) ? HOP_EAST : HOP_WEST;
    end else if (dst_y != loc_y) begin
      hop = (dst_y > loc_y) ? HOP_NORTH : HOP_SOUTH;
    end else if (dst_z != loc_z) begin
      hop = (dst_z > loc_z) ? HOP_UP : HOP_DOWN;
    end else begin
      hop = HOP_LOCAL;
    end
  end

endmodule

// File: rtl/qbuf_accept_mask.sv
module qbuf_accept_mask
  import qbuf_scan_alloc_pkg::*;
(
  input  hop_e             hop,
  output logic [NUM_Q-1:0] ok
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign ok[q] = q_accepts(q, hop);
  end

endmodule

// File: rtl/qbuf_scan_pick.sv
module qbuf_scan_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick,
  output logic         none
);

  // Prefix chain: seen[i] is high when some lower index already qualified.
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign pick[i]   = cand[i] & ~seen[i];
    assign seen[i+1] = seen[i] | cand[i];
  end

  assign none = ~seen[N];

endmodule

// File: rtl/qbuf_scan_alloc.sv
module qbuf_scan_alloc
  import qbuf_scan_alloc_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] dst_z,
  input  logic [CW-1:0] loc_x,
  input  logic [CW-1:0] loc_y,
  input  logic [CW-1:0] loc_z,
  input  logic [5:0]    q_not_full,
  output logic          rsp_vld,
  output logic [5:0]    q_sel,
  output logic          blocked,
  output logic [2:0]    hop_tag
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hop_e             hop;
  logic [NUM_Q-1:0] legal;
  logic [NUM_Q-1:0] cand;
  logic [NUM_Q-1:0] pick;
  logic             none;

  qbuf_hop_route #(.CW(CW)) route_i (
    .dst_x (dst_x),
    .dst_y (dst_y),
    .dst_z (dst_z),
    .loc_x (loc_x),
    .loc_y (loc_y),
    .loc_z (loc_z),
    .hop   (hop)
  );

  qbuf_accept_mask mask_i (
    .hop (hop),
    .ok  (legal)
  );

  assign cand = legal & q_not_full;

  qbuf_scan_pick #(.N(NUM_Q)) pick_i (
    .cand (cand),
    .pick (pick),
    .none (none)
  );

  // Next-state logic.
  logic             vld_d;
  logic [NUM_Q-1:0] sel_d;
  logic             blk_d;
  logic             tag_en;

  always_comb begin
    vld_d  = req_vld;
    sel_d  = req_vld ? pick : '0;
    blk_d  = req_vld & none;
    tag_en = req_vld;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_vld <= 1'b0;
      q_sel   <= '0;
      blocked <= 1'b0;
    end else begin
      rsp_vld <= vld_d;
      q_sel   <= sel_d;
      blocked <= blk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  hop_tag <= HOP_LOCAL;
    else if (tag_en) hop_tag <= hop;
  end

endmodule

// File: rtl/qbuf_scan_alloc_chk.sv
module qbuf_scan_alloc_chk
  import qbuf_scan_alloc_pkg::*;
#(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [5:0]    q_not_full,
  input logic          rsp_vld,
  input logic [5:0]    q_sel,
  input logic          blocked,
  input logic [2:0]    hop_tag
);

  function automatic logic [5:0] legal_of(input logic [2:0] t);
    logic [5:0] m;
    for (int q = 0; q < NUM_Q; q++) m[q] = q_accepts(q, hop_e'(t));
    return m;
  endfunction

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_sel));

  // R11
  sel_blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blocked && (q_sel != 6'd0)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && q_sel == 6'd0 && !blocked));

  // R5
  free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_sel != 6'd0) |-> ((q_sel & $past(q_not_full)) == q_sel));

  // R8
  blk_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> $past(req_vld));

  // R4
  legal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && q_sel != 6'd0) |-> ((q_sel & legal_of(hop_tag)) == q_sel));

  // R7
  west_to_east_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && hop_tag == 3'd2 && q_sel != 6'd0) |-> (q_sel == 6'b010000));

endmodule

bind qbuf_scan_alloc qbuf_scan_alloc_chk #(.CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .q_not_full (q_not_full),
  .rsp_vld    (rsp_vld),
  .q_sel      (q_sel),
  .blocked    (blocked),
  .hop_tag    (hop_tag)
);

// File: tb/qbuf_scan_alloc_tb.sv
module qbuf_scan_alloc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 3;
  localparam int WD_CYCLES  = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0;
  logic [CW-1:0] dst_x = '0, dst_y = '0, dst_z = '0;
  logic [CW-1:0] loc_x = '0, loc_y = '0, loc_z = '0;
  logic [5:0]    q_not_full = '0;
  logic          rsp_vld;
  logic [5:0]    q_sel;
  logic          blocked;
  logic [2:0]    hop_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbuf_scan_alloc #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
    .loc_x(loc_x), .loc_y(loc_y), .loc_z(loc_z),
    .q_not_full(q_not_full), .rsp_vld(rsp_vld),
    .q_sel(q_sel), .blocked(blocked), .hop_tag(hop_tag)
  );

  typedef struct {
    logic [5:0] sel;
    logic       blk;
    logic [2:0] tag;
    string      slbl;
    string      rlbl;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;
  bit   mon_on = 0;

  // Legal-queue table per hop, written from R4 as masks.
  function automatic logic [5:0] ref_legal(input logic [2:0] h);
    case (h)
      3'd0:    return 6'b111111;
      3'd1:    return 6'b100000;
      3'd2:    return 6'b010000;
      3'd3:    return 6'b111000;
      3'd4:    return 6'b110100;
      3'd5:    return 6'b111110;
      3'd6:    return 6'b111101;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check(input string lbl, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", lbl, what, act, exp);
    end
  endtask

  task automatic send(input logic [CW-1:0] dx, input logic [CW-1:0] dy,
                      input logic [CW-1:0] dz, input logic [CW-1:0] lx,
                      input logic [CW-1:0] ly, input logic [CW-1:0] lz,
                      input logic [5:0] nf, input string lbl);
    exp_t e;
    logic [2:0] h;
    logic [5:0] c;
    @(negedge clk);
    req_vld = 1'b1;
    dst_x = dx; dst_y = dy; dst_z = dz;
    loc_x = lx; loc_y = ly; loc_z = lz;
    q_not_full = nf;
    if (dx != lx)      begin h = (dx > lx) ? 3'd1 : 3'd2; e.rlbl = "R1"; end
    else if (dy != ly) begin h = (dy > ly) ? 3'd3 : 3'd4; e.rlbl = "R2"; end
    else if (dz != lz) begin h = (dz > lz) ? 3'd5 : 3'd6; e.rlbl = "R3"; end
    else               begin h = 3'd0;                    e.rlbl = "R3"; end
    c = ref_legal(h) & nf;
    e.sel = 6'd0;
    for (int i = 5; i >= 0; i--) if (c[i]) e.sel = 6'd1 << i;
    e.blk = (c == 6'd0);
    e.tag = h;
    if (lbl != "")                 e.slbl = lbl;
    else if (e.blk)                e.slbl = "R8";
    else if (h == 3'd1 || h == 3'd2) e.slbl = "R7";
    else if ($countones(c) > 1)    e.slbl = "R6";
    else                           e.slbl = "R4";
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 1'b0;
    end
  endtask

  // Monitor: compares each response against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      check("R11", "onehot_excl",
            {7'd0, ($countones(q_sel) <= 1) && !(blocked && q_sel != 0)}, 8'd1);
      if (rsp_vld) begin
        if (exp_q.size() == 0) begin
          check("R10", "unexpected_rsp", 8'd1, 8'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.rlbl, "hop_tag", {5'd0, hop_tag}, {5'd0, e.tag});
          check(e.slbl, "q_sel", {2'd0, q_sel}, {2'd0, e.sel});
          check(e.slbl, "blocked", {7'd0, blocked}, {7'd0, e.blk});
        end
      end else begin
        check("R9", "idle_out", {1'b0, q_sel, blocked}, 8'd0);
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset_rsp_vld", {7'd0, rsp_vld}, 8'd0);
    check("R10", "reset_q_sel", {2'd0, q_sel}, 8'd0);
    check("R10", "reset_blocked", {7'd0, blocked}, 8'd0);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;
    idle(2);

    // R1 / R7: West-bound flit goes only to the East queue
    send(3'd1, 3'd5, 3'd5, 3'd4, 3'd2, 3'd2, 6'b111111, "R7");
    send(3'd1, 3'd5, 3'd5, 3'd4, 3'd2, 3'd2, 6'b101111, "R8");
    // R1 / R7: East-bound flit goes only to the West queue
    send(3'd6, 3'd0, 3'd0, 3'd2, 3'd0, 3'd0, 6'b111111, "R7");
    // R2: North-bound -> South queue first (R6 order)
    send(3'd3, 3'd7, 3'd1, 3'd3, 3'd2, 3'd1, 6'b111111, "R6");
    // R5: South queue full -> East queue
    send(3'd3, 3'd7, 3'd1, 3'd3, 3'd2, 3'd1, 6'b110111, "R5");
    // R2: South-bound -> North queue
    send(3'd3, 3'd0, 3'd1, 3'd3, 3'd2, 3'd1, 6'b111111, "R6");
    // R3: Down-bound -> Up queue first
    send(3'd2, 3'd2, 3'd0, 3'd2, 3'd2, 3'd3, 6'b111111, "R6");
    // R3: Up-bound cannot use Up queue -> Down queue
    send(3'd2, 3'd2, 3'd7, 3'd2, 3'd2, 3'd3, 6'b111111, "R4");
    // R3: Local -> Up queue first
    send(3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 6'b111111, "R6");
    // R5: Local with only the West queue free
    send(3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 6'b100000, "R5");
    // R8: all queues full
    send(3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 6'b000000, "R8");
    // R8: North-bound with only illegal queues free
    send(3'd0, 3'd4, 3'd0, 3'd0, 3'd1, 3'd0, 6'b000111, "R8");
    idle(3);

    // Mixed pattern stream, back to back and with gaps.
    for (int k = 0; k < 400; k++) begin
      send(3'($urandom), 3'($urandom), 3'($urandom),
           3'($urandom), 3'($urandom), 3'($urandom),
           6'($urandom), "");
      if ((k % 7) == 0) idle(1);
    end
    idle(4);
    check("R10", "scoreboard_drained", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule